// File: doc/BRIEF.md
# Three-Counter Performance Monitor

This block counts processor activity for profiling software. It has one counter that counts only clock cycles and two general counters. Each general counter has an 8-bit event code that picks one line out of a vector of single-cycle event pulses driven by the core. One control word holds the global run bit, the per-counter interrupt enables, the overflow flags, the cycle divider select and both event codes. A small register port with a 2-bit address, a write strobe and a 32-bit data bus reads and writes the control word and the three counters.

There is no separate run bit for each counter. Software stops a general counter by giving it a code that never fires, such as 0x20. Overflow flags clear when a 1 is written to them. Software can therefore read the control word, change the event fields and write the whole word back in one step. Any flag that was set when it read the word is cleared by that write. All three flags drive one shared interrupt line, and software checks the flag bits to learn which counter caused it.

Top module: `perf_monitor`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Register addresses: 0 is the control word, 1 the cycle counter, 2 general counter 0, 3 general counter 1. Control fields: bit 0 run, bit 3 cycle divider, bits 6:4 interrupt enables for counter 0, counter 1 and the cycle counter, bits 10:8 overflow flags in that same order, bits 27:20 event code of counter 0, bits 19:12 event code of counter 1. Bits 1, 2, 7, 11 and 31:28 read as zero.
- R3: An event code from 0x00 to 0x12 selects bit `evt_in[code]`. The counter goes up by one on each rising clock edge at which the run bit is set and that bit is high.
- R4: Code 0xFF makes a general counter go up on every clock edge while running. Any other code, including 0x20, never makes it count.
- R5: While running with the divider clear, the cycle counter goes up on every clock edge. With the divider set, it goes up once every 64 clock edges. The divide-by-64 phase restarts when the cycle counter is cleared or written.
- R6: While the run bit is clear, no counter changes except through a register write.
- R7: A control write with bit 1 set clears both general counters. A control write with bit 2 set clears the cycle counter. These are one-time actions, and the bits are not stored.
- R8: Writing to a counter address loads that counter with the write data. The write takes priority over counting in the same cycle.
- R9: When a counter counts up from all ones and wraps to zero, its overflow flag is set.
- R10: Writing 1 to an overflow flag bit clears it, and writing 0 leaves it unchanged. Writing back a control value just read clears the flags that were set and leaves every other field as it was. If a wrap happens in the same cycle as the clearing write, the flag stays set.
- R11: `irq` is high exactly when at least one overflow flag is set and its interrupt enable is set.
- R12: Reading any register has no effect on the state of the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| evt_in | input | 19 | Single-cycle event pulses, one per event code 0x00 to 0x12 |
| irq | output | 1 | Shared overflow interrupt |

## Verification
A write, a clear and a count all act on the rising clock edge at which they are seen. Their result, and any flag they set, shows on `reg_rdata` and `irq` right after that edge, because the read path and `irq` are combinational from the registers. A change to the run bit or to an event code therefore first affects counting one edge later. The bench drives inputs just after an edge, steps its reference model at the next edge, and compares the read data and `irq` 1 ns later, before it drives new inputs. The divided cycle count is due 64 edges after its phase restarts, and the bench checks it by comparing on every cycle of a 200-cycle run.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned CODE_W  = 8;
    localparam int unsigned NUM_CTR = 3;

    // counter indices; also the order of the enable and flag fields
    localparam int unsigned IDX_EV0 = 0;
    localparam int unsigned IDX_EV1 = 1;
    localparam int unsigned IDX_CYC = 2;

    localparam logic [CODE_W-1:0] CODE_EVERY_CLK = 8'hFF;

    // control word bit positions
    localparam int unsigned B_RUN     = 0;
    localparam int unsigned B_CLR_EV  = 1;
    localparam int unsigned B_CLR_CYC = 2;
    localparam int unsigned B_DIV     = 3;
    localparam int unsigned B_IEN     = 4;
    localparam int unsigned B_FLAG    = 8;
    localparam int unsigned B_CODE1   = 12;
    localparam int unsigned B_CODE0   = 20;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_CYC  = 2'd1,
        A_EV0  = 2'd2,
        A_EV1  = 2'd3
    } pmu_addr_e;

    typedef struct packed {
        logic                run;
        logic                div;
        logic [NUM_CTR-1:0]  ien;
        logic [NUM_CTR-1:0]  flag;
        logic [CODE_W-1:0]   code0;
        logic [CODE_W-1:0]   code1;
    } pmu_ctrl_t;

    function automatic logic [1:0] ctr_addr(input int unsigned idx);
        case (idx)
            IDX_EV0: ctr_addr = A_EV0;
            IDX_EV1: ctr_addr = A_EV1;
            default: ctr_addr = A_CYC;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input pmu_ctrl_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[B_RUN]                      = c.run;
        r[B_DIV]                      = c.div;
        r[B_IEN +: NUM_CTR]           = c.ien;
        r[B_FLAG +: NUM_CTR]          = c.flag;
        r[B_CODE1 +: CODE_W]          = c.code1;
        r[B_CODE0 +: CODE_W]          = c.code0;
        return r;
    endfunction

endpackage

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel
    import pmu_pkg::*;
#(
    parameter int unsigned NUM_EVT = 19
) (
    input  logic [CODE_W-1:0]  code,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               hit
);

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (code == CODE_W'(i)) hit = evt_in[i];
        end
        if (code == CODE_EVERY_CLK) hit = 1'b1;
    end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clr,
    output logic [W-1:0] value,
    output logic         wrap
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (inc) begin
            cnt_d = cnt_q + W'(1);
            wrap  = &cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;

endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
    import pmu_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned NUM_EVT = 19,
    parameter int unsigned CYC_DIV = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         reg_addr,
    input  logic               reg_we,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);

    localparam int unsigned     PRE_W    = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_DIV - 1);

    typedef struct packed {
        pmu_ctrl_t        ctrl;
        logic [PRE_W-1:0] pre;
    } pmu_state_t;

    pmu_state_t st_d, st_q;

    logic                             wr_ctrl, clr_ev, clr_cyc, cyc_tick;
    logic [NUM_CTR-1:0]               ctr_inc, ctr_load, ctr_clr, ctr_wrap;
    logic [NUM_CTR-1:0][CNT_W-1:0]    cnt_val;
    logic [1:0][CODE_W-1:0]           ev_code;
    logic [1:0]                       ev_hit;
    logic [NUM_CTR-1:0]               ovf_flags;
    logic                             glob_en;

    assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
    assign clr_ev  = wr_ctrl && reg_wdata[B_CLR_EV];
    assign clr_cyc = wr_ctrl && reg_wdata[B_CLR_CYC];
    assign glob_en = st_q.ctrl.run;
    assign ovf_flags = st_q.ctrl.flag;

    assign ev_code[IDX_EV0] = st_q.ctrl.code0;
    assign ev_code[IDX_EV1] = st_q.ctrl.code1;

    assign cyc_tick = glob_en && (!st_q.ctrl.div || (st_q.pre == PRE_LAST));

    // event selection for the two general counters
    for (genvar e = 0; e < 2; e++) begin : g_sel
        pmu_evt_sel #(.NUM_EVT(NUM_EVT)) u_sel (
            .code   (ev_code[e]),
            .evt_in (evt_in),
            .hit    (ev_hit[e])
        );
        assign ctr_inc[e] = glob_en && ev_hit[e];
        assign ctr_clr[e] = clr_ev;
    end
    assign ctr_inc[IDX_CYC] = cyc_tick;
    assign ctr_clr[IDX_CYC] = clr_cyc;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        assign ctr_load[i] = reg_we && (reg_addr == ctr_addr(i));
        pmu_counter #(.W(CNT_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (ctr_inc[i]),
            .load     (ctr_load[i]),
            .load_val (reg_wdata[CNT_W-1:0]),
            .clr      (ctr_clr[i]),
            .value    (cnt_val[i]),
            .wrap     (ctr_wrap[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (glob_en && st_q.ctrl.div) begin
            st_d.pre = (st_q.pre == PRE_LAST) ? '0 : st_q.pre + PRE_W'(1);
        end
        if (clr_cyc || ctr_load[IDX_CYC]) begin
            st_d.pre = '0;
        end
        if (wr_ctrl) begin
            st_d.ctrl.run   = reg_wdata[B_RUN];
            st_d.ctrl.div   = reg_wdata[B_DIV];
            st_d.ctrl.ien   = reg_wdata[B_IEN +: NUM_CTR];
            st_d.ctrl.code0 = reg_wdata[B_CODE0 +: CODE_W];
            st_d.ctrl.code1 = reg_wdata[B_CODE1 +: CODE_W];
            st_d.ctrl.flag  = st_q.ctrl.flag & ~reg_wdata[B_FLAG +: NUM_CTR];
        end
        st_d.ctrl.flag = st_d.ctrl.flag | ctr_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = pack_ctrl(st_q.ctrl);
            A_CYC:   reg_rdata = DATA_W'(cnt_val[IDX_CYC]);
            A_EV0:   reg_rdata = DATA_W'(cnt_val[IDX_EV0]);
            default: reg_rdata = DATA_W'(cnt_val[IDX_EV1]);
        endcase
    end

    assign irq = |(ovf_flags & st_q.ctrl.ien);

endmodule

module perf_monitor_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_we,
    input logic [1:0]            reg_addr,
    input logic [CNT_W-1:0]      wr_data,
    input logic                  irq,
    input logic [2:0][CNT_W-1:0] cnt_val,
    input logic [2:0]            ovf_flags,
    input logic                  glob_en
);

    assert_load_cyc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd1) |=> (cnt_val[2] == $past(wr_data)));

    assert_clr_events_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd0 && wr_data[1]) |=> (cnt_val[0] == '0 && cnt_val[1] == '0));

    assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !reg_we) |=> $stable(cnt_val));

    assert_irq_has_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flags != 3'b000));

    assert_wrap_ev0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flags[0]) |-> (cnt_val[0] == '0));

    assert_wrap_ev1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flags[1]) |-> (cnt_val[1] == '0));

    assert_wrap_cyc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flags[2]) |-> (cnt_val[2] == '0));

endmodule

bind perf_monitor perf_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .wr_data   (reg_wdata[CNT_W-1:0]),
    .irq       (irq),
    .cnt_val   (cnt_val),
    .ovf_flags (ovf_flags),
    .glob_en   (glob_en)
);

// File: tb/sim_perf_monitor.sv
`timescale 1ns/1ps
module sim_perf_monitor;

    localparam int NEV = 19;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     reg_addr = '0;
    logic           reg_we = 1'b0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NEV-1:0] evt_in = '0;
    logic           irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    perf_monitor u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
    );

    // behavioural reference
    logic        m_run, m_div;
    logic [2:0]  m_ien, m_flag;
    logic [7:0]  m_c0, m_c1;
    logic [31:0] m_cnt [3];
    int          m_pre;

    task automatic m_reset();
        m_run = 0; m_div = 0; m_ien = 0; m_flag = 0; m_c0 = 0; m_c1 = 0; m_pre = 0;
        for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    endtask

    function automatic logic picks(input logic [7:0] code, input logic [NEV-1:0] ev);
        if (code == 8'hFF) return 1'b1;
        if (code < 8'(NEV)) return ev[code];
        return 1'b0;
    endfunction

    task automatic m_step(input logic [1:0] a, input logic we, input logic [31:0] wd,
                          input logic [NEV-1:0] ev);
        logic [2:0] inc, wr;
        logic       wc;
        int         la;
        inc[0] = m_run && picks(m_c0, ev);
        inc[1] = m_run && picks(m_c1, ev);
        inc[2] = m_run && (!m_div || m_pre == 63);
        if (m_run && m_div) m_pre = (m_pre == 63) ? 0 : m_pre + 1;
        wc = we && a == 2'd0;
        for (int i = 0; i < 3; i++) begin
            la = (i == 0) ? 2 : (i == 1) ? 3 : 1;
            wr[i] = 0;
            if (wc && ((i < 2) ? wd[1] : wd[2])) m_cnt[i] = 0;
            else if (we && a == 2'(la)) m_cnt[i] = wd;
            else if (inc[i]) begin
                wr[i] = (m_cnt[i] == 32'hFFFF_FFFF);
                m_cnt[i] = m_cnt[i] + 1;
            end
        end
        if ((wc && wd[2]) || (we && a == 2'd1)) m_pre = 0;
        if (wc) begin
            m_run = wd[0]; m_div = wd[3]; m_ien = wd[6:4];
            m_c0 = wd[27:20]; m_c1 = wd[19:12];
            m_flag = m_flag & ~wd[10:8];
        end
        m_flag = m_flag | wr;
    endtask

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return {4'b0, m_c0, m_c1, 1'b0, m_flag, 1'b0, m_ien, m_div, 2'b0, m_run};
            2'd1: return m_cnt[2];
            2'd2: return m_cnt[0];
            default: return m_cnt[1];
        endcase
    endfunction

    function automatic logic [31:0] cw(input logic run, input logic div, input logic [2:0] ien,
                                       input logic [7:0] c0, input logic [7:0] c1,
                                       input logic [2:0] w1c, input logic [1:0] rst);
        return {4'b0, c0, c1, 1'b0, w1c, 1'b0, ien, div, rst, run};
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // one clock: drive, step model at the edge, compare just after it
    task automatic cyc(input logic [1:0] a, input logic we, input logic [31:0] wd,
                       input logic [NEV-1:0] ev, input string tag);
        reg_addr = a; reg_we = we; reg_wdata = wd; evt_in = ev;
        @(posedge clk);
        m_step(a, we, wd, ev);
        #1;
        check(tag, "rdata", reg_rdata, m_read(a));
        check(tag, "irq", {31'b0, irq}, {31'b0, |(m_flag & m_ien)});
    endtask

    task automatic rd_all(input string tag);
        for (int k = 0; k < 4; k++) cyc(2'(k), 1'b0, 32'h0, '0, tag);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, read every address
        rd_all("R1");

        // R2: control field layout, reset bits not stored
        cyc(0, 1, 32'hFFFF_FFFF, '0, "R2");
        cyc(0, 0, 0, '0, "R2");
        cyc(0, 1, cw(0, 0, 3'b000, 8'h00, 8'h00, 3'b111, 2'b11), '0, "R2");

        // R3: every implemented code on counter 0, neighbour code on counter 1
        for (int c = 0; c < NEV; c++) begin
            cyc(0, 1, cw(1, 0, 3'b000, 8'(c), 8'((c + 1) % NEV), 3'b000, 2'b11), '0, "R3");
            for (int j = 0; j < 8; j++) cyc(2'(2 + (j % 2)), 0, 0, NEV'($urandom), "R3");
        end

        // R4: every-clock code and parked code 0x20
        cyc(0, 1, cw(1, 0, 3'b000, 8'hFF, 8'h20, 3'b000, 2'b01), '0, "R4");
        for (int j = 0; j < 12; j++) cyc(2'(2 + (j % 2)), 0, 0, '1, "R4");
        cyc(0, 1, cw(1, 0, 3'b000, 8'h13, 8'h08, 3'b000, 2'b01), '0, "R4");
        for (int j = 0; j < 6; j++) cyc(2'(2 + (j % 2)), 0, 0, '1, "R4");

        // R5: cycle counter, undivided then divided by 64
        cyc(0, 1, cw(1, 0, 3'b000, 8'h20, 8'h20, 3'b000, 2'b10), '0, "R5");
        for (int j = 0; j < 10; j++) cyc(1, 0, 0, '0, "R5");
        cyc(0, 1, cw(1, 1, 3'b000, 8'h20, 8'h20, 3'b000, 2'b10), '0, "R5");
        for (int j = 0; j < 200; j++) cyc(1, 0, 0, '0, "R5");

        // R6: stopped, events present, nothing moves
        cyc(0, 1, cw(1, 0, 3'b000, 8'hFF, 8'h07, 3'b000, 2'b00), '0, "R6");
        for (int j = 0; j < 5; j++) cyc(2, 0, 0, '1, "R6");
        cyc(0, 1, cw(0, 0, 3'b000, 8'hFF, 8'h07, 3'b000, 2'b00), '1, "R6");
        for (int j = 0; j < 6; j++) cyc(2'(j % 4), 0, 0, '1, "R6");

        // R7: separate reset bits
        cyc(0, 1, cw(0, 0, 3'b000, 8'hFF, 8'h07, 3'b000, 2'b01), '0, "R7");
        rd_all("R7");
        cyc(1, 1, 32'h55, '0, "R7");
        cyc(2, 1, 32'h66, '0, "R7");
        cyc(0, 1, cw(0, 0, 3'b000, 8'hFF, 8'h07, 3'b000, 2'b10), '0, "R7");
        rd_all("R7");

        // R8: loads, load beating a count in the same cycle
        cyc(0, 1, cw(1, 0, 3'b000, 8'hFF, 8'hFF, 3'b000, 2'b00), '0, "R8");
        cyc(2, 1, 32'h1234_5678, '0, "R8");
        cyc(3, 1, 32'hA5A5_0000, '0, "R8");
        cyc(1, 1, 32'h0000_0100, '0, "R8");
        rd_all("R8");

        // R9/R11: wraps set flags, irq follows enables
        cyc(0, 1, cw(1, 0, 3'b001, 8'hFF, 8'h20, 3'b000, 2'b00), '0, "R9");
        cyc(2, 1, 32'hFFFF_FFFD, '0, "R9");
        cyc(3, 1, 32'hFFFF_FFFF, '0, "R9");
        cyc(1, 1, 32'hFFFF_FFFE, '0, "R9");
        for (int j = 0; j < 6; j++) cyc(2'(j % 4), 0, 0, '0, "R9");
        cyc(0, 1, cw(1, 0, 3'b100, 8'hFF, 8'h05, 3'b000, 2'b00), '0, "R11");
        cyc(0, 1, cw(1, 0, 3'b010, 8'hFF, 8'h05, 3'b000, 2'b00), '0, "R11");
        cyc(0, 0, 0, '0, "R11");
        cyc(3, 0, 0, 19'h20, "R11");
        cyc(0, 0, 0, '0, "R11");

        // R12: repeated reads leave flags and counts alone
        cyc(0, 1, cw(0, 0, 3'b111, 8'hFF, 8'h05, 3'b000, 2'b00), '0, "R12");
        for (int j = 0; j < 8; j++) cyc(2'(j % 4), 0, 0, '1, "R12");

        // R10: read-modify-write clears flags, keeps fields
        cyc(0, 0, 0, '0, "R10");
        v = reg_rdata;
        cyc(0, 1, v, '0, "R10");
        cyc(0, 0, 0, '0, "R10");
        // R10: flag set by a wrap in the same cycle as its clear stays set
        cyc(0, 1, cw(1, 0, 3'b001, 8'hFF, 8'h20, 3'b000, 2'b00), '0, "R10");
        cyc(2, 1, 32'hFFFF_FFFE, '0, "R10");
        cyc(2, 0, 0, '0, "R10");
        cyc(0, 1, cw(1, 0, 3'b001, 8'hFF, 8'h20, 3'b001, 2'b00), '0, "R10");
        cyc(0, 0, 0, '0, "R10");
        cyc(0, 1, cw(1, 0, 3'b001, 8'hFF, 8'h20, 3'b001, 2'b00), '0, "R10");
        cyc(0, 0, 0, '0, "R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule